// File: doc/BRIEF.md
# Read Latency Setting Interlock

This block holds the number of wait cycles that the memory read path adds before it returns data. It makes sure that number never changes while a read is being served. Software changes the setting through a one-register control port. Memory reads come in on a separate stream port. The two ports never block each other's reads, but a new setting is held back until read traffic pauses.

A write to the control register is accepted at once into a single pending slot. The new value takes effect on the first cycle in which the read path is idle. Until then, the control port refuses every further access, whether read or write. Software can therefore issue a readback directly after the write. The readback completes only once the new latency is in force, which makes it the synchronisation point. How long it takes is open-ended, because it depends only on when read traffic stops. The memory array itself is outside the block: the read path returns the request address as a stand-in for the fetched word.

Both the memory request/response port and the control port use valid/ready. A request is taken on a clock edge where valid and ready are both high. A response stays valid, with stable content, until the consumer raises ready. The read path holds at most one read at a time.

Top module: `ws_interlock`

## Requirements
- R1: After reset the wait setting equals parameter RESET_WS, reg_ready and rd_req_ready are 1, and rd_resp_valid is 0.
- R2: A read accepted on an edge presents rd_resp_valid, carrying the accepted rd_req_addr on rd_resp_addr, exactly 1 + W cycles later. W is the wait setting in force at acceptance.
- R3: A response remains valid with a stable rd_resp_addr while rd_resp_ready is 0. rd_req_ready is 1 only when no read is held, or when the held response completes in that cycle.
- R4: A write accepted while the read path is idle sets the wait setting on that same edge. The read path is idle when no read is held and no read is accepted in that cycle.
- R5: A write accepted while the read path is not idle does not change the wait setting. The written value is applied on the first later edge on which the read path is idle.
- R6: A read request arriving while a write is pending is accepted as normal and served with the old wait setting. The pending write keeps waiting.
- R7: While a write is pending, reg_ready is 0 for both reads and writes, so further register accesses stall.
- R8: A register read returns the wait setting in force in that cycle. A readback issued right after a write therefore returns the new value.
- R9: The wait setting lives in reg_wdata/reg_rdata bits [WS_W-1:0]. Higher bits of a write are ignored and read as 0.
- R10: The wait setting never changes on an edge where the read path is not idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_valid | input | 1 | Register access request valid |
| reg_ready | output | 1 | Register access accepted this cycle |
| reg_write | input | 1 | 1 for a write, 0 for a read |
| reg_wdata | input | REG_W | Write data, setting in bits [WS_W-1:0] |
| reg_rdata | output | REG_W | Read data, valid in the cycle of a read handshake |
| rd_req_valid | input | 1 | Memory read request valid |
| rd_req_ready | output | 1 | Memory read request accepted |
| rd_req_addr | input | ADDR_W | Memory read address |
| rd_resp_valid | output | 1 | Read response valid |
| rd_resp_ready | input | 1 | Consumer takes the response |
| rd_resp_addr | output | ADDR_W | Response payload (address stand-in for data) |

## Verification
The hardest situation to reach is a pending write that is held off by read traffic for many cycles, with new reads arriving while it waits. The bench gets there by holding rd_req_valid high continuously, with the response consumer stalling at times, before and after posting a write. It then issues a readback that must stall until the stream ends. Randomised traffic on both ports also hits the single-cycle gaps in which a pending value gets applied, as well as accepted reads that land on the exact edge a response completes.

// File: rtl/ws_interlock_pkg.sv
package ws_interlock_pkg;
  typedef enum logic {
    CTL_APPLIED = 1'b0,
    CTL_PENDING = 1'b1
  } ctl_state_e;
endpackage

// File: rtl/ws_rd_timer.sv
module ws_rd_timer #(
  parameter int ADDR_W = 12,
  parameter int WS_W   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WS_W-1:0]   ws_i,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              resp_valid,
  input  logic              resp_ready,
  output logic [ADDR_W-1:0] resp_addr,
  output logic              idle_o
);
  logic              busy_q;
  logic [WS_W-1:0]   cnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic              done, acc;

  assign resp_valid = busy_q && (cnt_q == '0);
  assign done       = resp_valid && resp_ready;
  assign req_ready  = !busy_q || done;
  assign acc        = req_valid && req_ready;
  assign idle_o     = !busy_q && !acc;
  assign resp_addr  = addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      addr_q <= '0;
    end else if (acc) begin
      busy_q <= 1'b1;
      cnt_q  <= ws_i;
      addr_q <= req_addr;
    end else if (done) begin
      busy_q <= 1'b0;
    end else if (busy_q && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/ws_setting_ctrl.sv
module ws_setting_ctrl
  import ws_interlock_pkg::*;
#(
  parameter int              REG_W    = 8,
  parameter int              WS_W     = 1,
  parameter logic [WS_W-1:0] RESET_WS = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_valid,
  output logic             reg_ready,
  input  logic             reg_write,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             idle_i,
  output logic [WS_W-1:0]  ws_o,
  output logic             pend_o
);
  ctl_state_e      state_q;
  logic [WS_W-1:0] ws_q, pval_q;
  logic            wr_acc;

  assign reg_ready = (state_q == CTL_APPLIED);
  assign wr_acc    = reg_valid && reg_write && reg_ready;
  assign ws_o      = ws_q;
  assign pend_o    = (state_q == CTL_PENDING);

  always_comb begin
    reg_rdata             = '0;
    reg_rdata[WS_W-1:0]   = ws_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= CTL_APPLIED;
      ws_q    <= RESET_WS;
      pval_q  <= '0;
    end else begin
      case (state_q)
        CTL_APPLIED: if (wr_acc) begin
          if (idle_i) ws_q <= reg_wdata[WS_W-1:0];
          else begin
            pval_q  <= reg_wdata[WS_W-1:0];
            state_q <= CTL_PENDING;
          end
        end
        default: if (idle_i) begin
          ws_q    <= pval_q;
          state_q <= CTL_APPLIED;
        end
      endcase
    end
  end
endmodule

// File: rtl/ws_interlock.sv
module ws_interlock #(
  parameter int              REG_W    = 8,
  parameter int              WS_W     = 1,
  parameter int              ADDR_W   = 12,
  parameter logic [WS_W-1:0] RESET_WS = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_valid,
  output logic              reg_ready,
  input  logic              reg_write,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              rd_req_valid,
  output logic              rd_req_ready,
  input  logic [ADDR_W-1:0] rd_req_addr,
  output logic              rd_resp_valid,
  input  logic              rd_resp_ready,
  output logic [ADDR_W-1:0] rd_resp_addr
);
  logic [WS_W-1:0] ws_q;
  logic            rd_idle;
  logic            pend;

  ws_rd_timer #(.ADDR_W(ADDR_W), .WS_W(WS_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .ws_i(ws_q),
    .req_valid(rd_req_valid), .req_ready(rd_req_ready), .req_addr(rd_req_addr),
    .resp_valid(rd_resp_valid), .resp_ready(rd_resp_ready), .resp_addr(rd_resp_addr),
    .idle_o(rd_idle)
  );

  ws_setting_ctrl #(.REG_W(REG_W), .WS_W(WS_W), .RESET_WS(RESET_WS)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .reg_valid(reg_valid), .reg_ready(reg_ready), .reg_write(reg_write),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .idle_i(rd_idle), .ws_o(ws_q), .pend_o(pend)
  );
endmodule

// File: rtl/ws_interlock_chk.sv
module ws_interlock_chk #(
  parameter int REG_W  = 8,
  parameter int WS_W   = 1,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_req_valid,
  input logic              rd_req_ready,
  input logic              rd_resp_valid,
  input logic              rd_resp_ready,
  input logic [ADDR_W-1:0] rd_resp_addr,
  input logic              reg_ready,
  input logic [REG_W-1:0]  reg_rdata,
  input logic [WS_W-1:0]   ws_q,
  input logic              rd_idle,
  input logic              pend
);
  p_ws_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ws_q) |-> $past(rd_idle));

  p_lat_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && rd_req_ready && ws_q == '0) |=> rd_resp_valid);

  p_lat_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && rd_req_ready && ws_q != '0) |=> !rd_resp_valid);

  p_resp_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_resp_valid && !rd_resp_ready) |=> (rd_resp_valid && $stable(rd_resp_addr)));

  p_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> !reg_ready);

  p_apply_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && rd_idle) |=> !pend);

  p_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata >> WS_W) == '0);
endmodule

bind ws_interlock ws_interlock_chk #(.REG_W(REG_W), .WS_W(WS_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
  .rd_resp_valid(rd_resp_valid), .rd_resp_ready(rd_resp_ready), .rd_resp_addr(rd_resp_addr),
  .reg_ready(reg_ready), .reg_rdata(reg_rdata), .ws_q(ws_q), .rd_idle(rd_idle), .pend(pend)
);

// File: tb/ws_interlock_bench.sv
module ws_interlock_bench;
  localparam int REG_W = 8, WS_W = 1, ADDR_W = 12;
  localparam int RESET_WS = 1;
  localparam real HALF = 4.0;

  logic clk = 0, rst_n = 0;
  logic reg_valid = 0, reg_write = 0;
  logic [REG_W-1:0] reg_wdata = '0;
  logic reg_ready;
  logic [REG_W-1:0] reg_rdata;
  logic rd_req_valid = 0, rd_resp_ready = 1;
  logic [ADDR_W-1:0] rd_req_addr = '0;
  logic rd_req_ready, rd_resp_valid;
  logic [ADDR_W-1:0] rd_resp_addr;

  always #(HALF) clk = ~clk;

  ws_interlock #(.REG_W(REG_W), .WS_W(WS_W), .ADDR_W(ADDR_W), .RESET_WS(RESET_WS)) u_ws_interlock (
    .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_ready(reg_ready),
    .reg_write(reg_write), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_resp_valid(rd_resp_valid), .rd_resp_ready(rd_resp_ready), .rd_resp_addr(rd_resp_addr));

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: a queue of outstanding reads with due cycles
  typedef struct { int addr; int due; } rd_t;
  rd_t q[$];
  int  cyc = 0;
  int  m_ws = RESET_WS;
  bit  m_pend = 0;
  int  m_pval = 0;
  bit  run_model = 0;

  function automatic bit e_resp_valid();
    return q.size() > 0 && cyc >= q[0].due;
  endfunction
  function automatic bit e_rd_ready();
    return q.size() == 0 || (e_resp_valid() && rd_resp_ready);
  endfunction
  function automatic bit e_idle();
    return q.size() == 0 && !(rd_req_valid && e_rd_ready());
  endfunction

  always @(negedge clk) if (run_model) begin
    check("R2 R6 R10 rd_resp_valid", rd_resp_valid, e_resp_valid());
    if (e_resp_valid()) check("R2 rd_resp_addr", rd_resp_addr, q[0].addr);
    check("R3 rd_req_ready", rd_req_ready, e_rd_ready());
    check("R7 reg_ready", reg_ready, !m_pend);
    if (reg_valid && !reg_write && !m_pend) check("R8 R9 reg_rdata", reg_rdata, m_ws);
  end

  always @(posedge clk) if (run_model) begin
    bit acc, idl, rv;
    acc = rd_req_valid && e_rd_ready();
    idl = e_idle();
    rv  = e_resp_valid();
    if (rv && rd_resp_ready) void'(q.pop_front());
    if (acc) q.push_back('{addr: int'(rd_req_addr), due: cyc + 1 + m_ws});
    if (m_pend) begin
      if (idl) begin m_ws = m_pval; m_pend = 0; end
    end else if (reg_valid && reg_write) begin
      if (idl) m_ws = reg_wdata & ((1 << WS_W) - 1);
      else begin m_pval = reg_wdata & ((1 << WS_W) - 1); m_pend = 1; end
    end
    cyc++;
  end

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic reg_op(bit wr, int wd, output int rd, output int waited);
    bit hs;
    reg_valid = 1; reg_write = wr; reg_wdata = wd[REG_W-1:0];
    waited = 0;
    do begin
      @(negedge clk); hs = reg_ready; rd = int'(reg_rdata);
      if (!hs) waited++;
      tick();
    end while (!hs);
    reg_valid = 0; reg_write = 0;
  endtask

  task automatic single_read(int a, output int lat);
    bit hs;
    rd_req_valid = 1; rd_req_addr = a[ADDR_W-1:0];
    do begin @(negedge clk); hs = rd_req_ready; tick(); end while (!hs);
    rd_req_valid = 0; lat = 1;
    forever begin
      @(negedge clk);
      if (rd_resp_valid) break;
      lat++;
      tick();
    end
    check("R2 addr", rd_resp_addr, a);
    tick();
  endtask

  initial begin
    int v, w, lat;
    repeat (3) tick();
    @(negedge clk);
    check("R1 reg_ready", reg_ready, 1);
    check("R1 rd_req_ready", rd_req_ready, 1);
    check("R1 rd_resp_valid", rd_resp_valid, 0);
    check("R1 reset setting", reg_rdata, RESET_WS);
    rst_n = 1; tick();
    run_model = 1;

    single_read(12'h123, lat);
    check("R2 latency ws1", lat, 2);
    reg_op(1, 0, v, w);
    check("R4 idle write no stall", w, 0);
    reg_op(0, 0, v, w);
    check("R4 R8 readback", v, 0);
    single_read(12'h055, lat);
    check("R2 latency ws0", lat, 1);

    reg_op(1, 8'hFF, v, w);
    reg_op(0, 0, v, w);
    check("R9 upper bits ignored", v, 1);

    // pending write held off by a continuous read stream
    reg_op(1, 0, v, w);
    rd_req_valid = 1;
    fork
      begin
        for (int i = 0; i < 40; i++) begin
          rd_req_addr = ADDR_W'(i);
          rd_resp_ready = (i % 7 != 3);
          tick();
        end
        rd_req_valid = 0; rd_resp_ready = 1;
      end
      begin
        repeat (3) tick();
        reg_op(1, 1, v, w);
        reg_op(0, 0, v, w);
        check("R5 R6 R7 readback stalled", w > 20, 1);
        check("R8 readback new value", v, 1);
      end
    join
    repeat (4) tick();

    // random traffic on both ports
    for (int i = 0; i < 3000; i++) begin
      rd_req_valid  = ($urandom % 4) != 0;
      rd_req_addr   = ADDR_W'($urandom);
      rd_resp_ready = ($urandom % 4) != 0;
      reg_valid     = ($urandom % 6) == 0;
      reg_write     = $urandom % 2;
      reg_wdata     = REG_W'($urandom);
      tick();
    end
    reg_valid = 0; rd_req_valid = 0; rd_resp_ready = 1;
    repeat (5) tick();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(2.0 * HALF * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule